// File: doc/BRIEF.md
# Implicit Polynomial-Sequencing Reseed Controller

This controller feeds a multi-polynomial LFSR pattern generator during deterministic self-test. It reads seeds from a seed memory one after another, starting at address 0. It hands each seed to the LFSR together with a feedback-configuration index and a one-cycle load strobe. It then waits until the LFSR reports that the pattern has been shifted out. No polynomial identifier is stored with a seed. The index comes from the seed's position in the run, so the seeds must be placed in memory in an order that suits the selected mode.

Two modes are offered. In periodic mode the index is a counter modulo p, and it steps once for every pattern. In next-bit mode every memory word carries one extra flag bit above the seed. When a seed's flag is set, a q-bit configuration counter steps after that seed's pattern, so the next seed uses the next configuration. A run covers a programmed number of patterns. It may stop at any point in a period. When the last pattern is complete, the controller raises a completion flag and holds it.

Top module: `reseed_ctrl`

## Requirements
- R1: After reset the controller is idle. `load_o`, `mem_rd_o`, `busy_o` and `all_done_o` are all low, and `poly_idx_o` is 0.
- R2: Pattern k of a run reads memory address k. `mem_rd_o` is high for one cycle. The seed (word bits SEED_W-1:0) appears on `seed_o` together with a one-cycle `load_o` pulse two cycles after the read.
- R3: In periodic mode (`mode_i`=0) pattern k is loaded with index k mod p, where p is `period_i` (p of 0 acts as 1).
- R4: In next-bit mode (`mode_i`=1) pattern 0 uses index 0. Pattern k+1 uses the index of pattern k plus that pattern's flag (word bit SEED_W), wrapping modulo 2^CFG_W.
- R5: Exactly one load is issued per pattern. The next memory read does not happen until `lfsr_done_i` has been seen after the current load.
- R6: `lfsr_done_i` has no effect in the cycle in which `load_o` is high, and none outside a wait for the LFSR.
- R7: After exactly `pattern_count_i` loads the controller raises `all_done_o` and holds it until a new start. This holds even when the count is not a multiple of p.
- R8: A start with a pattern count of 0 raises `all_done_o` on the next cycle, with no memory read and no load.
- R9: `start_i` is ignored while a run is in progress. Mode, period and count are sampled only when a start is accepted.
- R10: A start accepted after completion clears `all_done_o` and restarts from address 0 with index 0.
- R11: `busy_o` is high from the cycle after an accepted start until the last pattern is complete. It is never high together with `all_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run (accepted only when idle or finished) |
| mode_i | input | 1 | 0 = periodic, 1 = next-bit |
| period_i | input | CFG_W+1 | Number of polynomials p in periodic mode |
| pattern_count_i | input | ADDR_W+1 | Patterns in the run |
| mem_rd_o | output | 1 | Seed memory read enable |
| mem_addr_o | output | ADDR_W | Seed memory address |
| mem_data_i | input | SEED_W+1 | Memory word: flag bit on top, seed below, valid one cycle after the read |
| seed_o | output | SEED_W | Seed to the LFSR |
| poly_idx_o | output | CFG_W | Feedback configuration index |
| load_o | output | 1 | One-cycle strobe: load the seed and start the pattern |
| lfsr_done_i | input | 1 | LFSR has finished the current pattern |
| busy_o | output | 1 | Run in progress |
| all_done_o | output | 1 | All programmed patterns issued |

## Verification
The assertions assume a memory with a single cycle of read latency. They also assume that `lfsr_done_i` is the only thing that moves a waiting controller on, so checks on strobe spacing and index stepping depend only on the controller's own sequencing. The bench models the memory as a registered array. It answers each load with a done pulse one or more cycles after the strobe. It changes `mode_i`, `period_i` and `pattern_count_i` only between runs, except where a stray start or an early done is injected on purpose to exercise R6 and R9.

// File: rtl/reseed_pkg.sv
package reseed_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_LOAD   = 3'd2,
    ST_WAIT   = 3'd3,
    ST_ADV    = 3'd4,
    ST_FINISH = 3'd5
  } rs_state_e;

  localparam logic MODE_PERIODIC = 1'b0;
  localparam logic MODE_NEXTBIT  = 1'b1;
endpackage

// File: rtl/reseed_fsm.sv
module reseed_fsm
  import reseed_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      zero_cnt_i,
  input  logic      last_i,
  input  logic      done_ok_i,
  output rs_state_e state_o,
  output logic      kick_o
);
  rs_state_e state_q, state_d;

  assign kick_o = start_i && (state_q == ST_IDLE || state_q == ST_FINISH);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_FINISH: if (start_i) state_d = zero_cnt_i ? ST_FINISH : ST_READ;
      ST_READ:            state_d = ST_LOAD;
      ST_LOAD:            state_d = ST_WAIT;
      ST_WAIT:            if (done_ok_i) state_d = ST_ADV;
      ST_ADV:             state_d = last_i ? ST_FINISH : ST_READ;
      default:            state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/reseed_cfg_ctr.sv
module reseed_cfg_ctr
  import reseed_pkg::*;
#(
  parameter int CFG_W = 2,
  localparam int PER_W = CFG_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             mode_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             flag_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             mode_q;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] cfg_inc;

  assign cfg_inc = {1'b0, cfg_q} + PER_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      mode_q <= MODE_PERIODIC;
      per_q  <= PER_W'(1);
    end else if (clear_i) begin
      cfg_q  <= '0;
      mode_q <= mode_i;
      per_q  <= period_i;
    end else if (step_i) begin
      if (mode_q == MODE_PERIODIC) begin
        // mod-p wrap; p of 0 or 1 pins the index at 0
        cfg_q <= (cfg_inc >= per_q) ? '0 : cfg_inc[CFG_W-1:0];
      end else if (flag_i) begin
        cfg_q <= cfg_q + CFG_W'(1);
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/reseed_seq.sv
module reseed_seq #(
  parameter int SEED_W = 16,
  parameter int ADDR_W = 8,
  localparam int CNT_W  = ADDR_W + 1,
  localparam int WORD_W = SEED_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              capture_i,
  input  logic              step_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SEED_W-1:0] seed_o,
  output logic              flag_o,
  output logic              load_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  issued_q, cnt_q;
  logic [SEED_W-1:0] seed_q;
  logic              flag_q, load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      issued_q <= '0;
      cnt_q    <= '0;
    end else if (clear_i) begin
      addr_q   <= '0;
      issued_q <= '0;
      cnt_q    <= count_i;
    end else if (step_i) begin
      addr_q   <= addr_q + ADDR_W'(1);
      issued_q <= issued_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q <= '0;
      flag_q <= 1'b0;
      load_q <= 1'b0;
    end else begin
      load_q <= capture_i;
      if (capture_i) begin
        seed_q <= word_i[SEED_W-1:0];
        flag_q <= word_i[SEED_W];
      end
    end
  end

  assign last_o = (issued_q + CNT_W'(1)) == cnt_q;
  assign addr_o = addr_q;
  assign seed_o = seed_q;
  assign flag_o = flag_q;
  assign load_o = load_q;
endmodule

// File: rtl/reseed_ctrl.sv
module reseed_ctrl
  import reseed_pkg::*;
#(
  parameter int SEED_W = 16,
  parameter int CFG_W  = 2,
  parameter int ADDR_W = 8,
  localparam int PER_W  = CFG_W + 1,
  localparam int CNT_W  = ADDR_W + 1,
  localparam int WORD_W = SEED_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [CNT_W-1:0]  pattern_count_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic [SEED_W-1:0] seed_o,
  output logic [CFG_W-1:0]  poly_idx_o,
  output logic              load_o,
  input  logic              lfsr_done_i,
  output logic              busy_o,
  output logic              all_done_o
);
  rs_state_e state;
  logic      kick, last, flag, done_ok, step, capture;

  // done is taken only once the load strobe has gone
  assign done_ok = (state == ST_WAIT) && lfsr_done_i && !load_o;
  assign step    = (state == ST_ADV);
  assign capture = (state == ST_LOAD);

  reseed_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .zero_cnt_i (pattern_count_i == '0),
    .last_i     (last),
    .done_ok_i  (done_ok),
    .state_o    (state),
    .kick_o     (kick)
  );

  reseed_seq #(.SEED_W(SEED_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (kick),
    .capture_i (capture),
    .step_i    (step),
    .count_i   (pattern_count_i),
    .word_i    (mem_data_i),
    .addr_o    (mem_addr_o),
    .seed_o    (seed_o),
    .flag_o    (flag),
    .load_o    (load_o),
    .last_o    (last)
  );

  reseed_cfg_ctr #(.CFG_W(CFG_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (kick),
    .step_i   (step),
    .mode_i   (mode_i),
    .period_i (period_i),
    .flag_i   (flag),
    .cfg_o    (poly_idx_o)
  );

  assign mem_rd_o   = (state == ST_READ);
  assign all_done_o = (state == ST_FINISH);
  assign busy_o     = (state != ST_IDLE) && (state != ST_FINISH);
endmodule

// File: rtl/reseed_ctrl_chk.sv
module reseed_ctrl_chk #(
  parameter int CFG_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             mem_rd_o,
  input logic             load_o,
  input logic             lfsr_done_i,
  input logic [CFG_W-1:0] poly_idx_o,
  input logic             busy_o,
  input logic             all_done_o
);
  p_load_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

  p_read_to_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> ##1 load_o);

  p_idx_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && poly_idx_o != $past(poly_idx_o)) |->
      (poly_idx_o == CFG_W'($past(poly_idx_o) + 1'b1) || poly_idx_o == '0));

  p_idx_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> $stable(poly_idx_o));

  p_no_read_after_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !mem_rd_o);

  p_early_done_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && lfsr_done_i) |=> ##1 !mem_rd_o);

  p_done_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_done_o && !start_i) |=> all_done_o);

  p_quiet_when_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_done_o |-> (!load_o && !mem_rd_o));

  p_busy_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && all_done_o));

  p_read_in_run_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || load_o) |-> busy_o);
endmodule

bind reseed_ctrl reseed_ctrl_chk #(.CFG_W(CFG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mem_rd_o    (mem_rd_o),
  .load_o      (load_o),
  .lfsr_done_i (lfsr_done_i),
  .poly_idx_o  (poly_idx_o),
  .busy_o      (busy_o),
  .all_done_o  (all_done_o)
);

// File: tb/reseed_ctrl_tb.sv
module reseed_ctrl_tb;
  localparam int SEED_W = 16;
  localparam int CFG_W  = 2;
  localparam int ADDR_W = 8;
  localparam int PER_W  = CFG_W + 1;
  localparam int CNT_W  = ADDR_W + 1;
  localparam int WORD_W = SEED_W + 1;
  localparam int MEM_D  = 1 << ADDR_W;

  typedef struct packed {
    logic [SEED_W-1:0] seed;
    logic [CFG_W-1:0]  idx;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              mode = 1'b0;
  logic [PER_W-1:0]  period = '0;
  logic [CNT_W-1:0]  count = '0;
  logic              mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_q = '0;
  logic [SEED_W-1:0] seed;
  logic [CFG_W-1:0]  poly_idx;
  logic              load;
  logic              lfsr_done = 1'b0;
  logic              busy, all_done;

  logic [WORD_W-1:0] mem [MEM_D];
  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  int   rd_cnt = 0, ld_cnt = 0;
  bit   reported = 1'b0;

  always #4 clk = ~clk;

  reseed_ctrl #(.SEED_W(SEED_W), .CFG_W(CFG_W), .ADDR_W(ADDR_W)) u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .start_i         (start),
    .mode_i          (mode),
    .period_i        (period),
    .pattern_count_i (count),
    .mem_rd_o        (mem_rd),
    .mem_addr_o      (mem_addr),
    .mem_data_i      (mem_q),
    .seed_o          (seed),
    .poly_idx_o      (poly_idx),
    .load_o          (load),
    .lfsr_done_i     (lfsr_done),
    .busy_o          (busy),
    .all_done_o      (all_done)
  );

  always @(posedge clk) if (mem_rd) mem_q <= mem[mem_addr];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    end
  endtask

  function automatic logic [WORD_W-1:0] word_of(int k, int salt);
    logic [SEED_W-1:0] s;
    s = SEED_W'((k * 40503 + salt * 977 + 13) ^ (k << 5));
    return {((k * 5 + salt) % 3) != 0, s};
  endfunction

  // monitor: pops the scoreboard on every load, tracks read addresses
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) begin
        check(mem_addr == ADDR_W'(rd_cnt), "R2", "read address", mem_addr, rd_cnt);
        rd_cnt++;
      end
      if (load) begin
        ld_cnt++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "unexpected load", ld_cnt, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(seed == e.seed, "R2", "seed", seed, e.seed);
          check(poly_idx == e.idx, mode ? "R4" : "R3", "poly index", poly_idx, e.idx);
        end
      end
    end
  end

  task automatic run(input bit md, input int p, input int n, input int dly,
                     input int salt, input bit early_done, input bit stray_start);
    int idx;
    for (int k = 0; k < MEM_D; k++) mem[k] = word_of(k, salt);
    idx = 0;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      logic [WORD_W-1:0] w;
      w = word_of(k, salt);
      e.seed = w[SEED_W-1:0];
      if (md) begin
        e.idx = CFG_W'(idx);
        if (w[SEED_W]) idx = (idx + 1) % (1 << CFG_W);
      end else begin
        e.idx = CFG_W'(k % ((p == 0) ? 1 : p));
      end
      exp_q.push_back(e);
    end
    rd_cnt = 0;
    ld_cnt = 0;
    mode = md;
    period = PER_W'(p);
    count = CNT_W'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R11", "busy after start", busy, 1);
    check(all_done == 1'b0, "R10", "done cleared by start", all_done, 0);
    for (int j = 0; j < n; j++) begin
      while (!load) @(negedge clk);
      if (early_done && j == 1) begin
        lfsr_done = 1'b1;
        @(negedge clk);
        lfsr_done = 1'b0;
        for (int c = 0; c < 3; c++) begin
          check(!mem_rd && !load, "R6", "early done taken", mem_rd, 0);
          @(negedge clk);
        end
      end else begin
        for (int c = 0; c < dly; c++) begin
          if (stray_start && j == 0 && c == 0) begin
            start = 1'b1;
            // new inputs must not be picked up either
            mode = ~md;
            count = CNT_W'(1);
          end
          @(negedge clk);
          start = 1'b0;
          mode = md;
          count = CNT_W'(n);
          check(!mem_rd, "R5", "read before done", mem_rd, 0);
        end
      end
      lfsr_done = 1'b1;
      @(negedge clk);
      lfsr_done = 1'b0;
    end
    @(negedge clk);
    check(all_done == 1'b1, "R7", "all_done after last", all_done, 1);
    check(busy == 1'b0, "R11", "busy after finish", busy, 0);
    check(ld_cnt == n, "R7", "load count", ld_cnt, n);
    check(exp_q.size() == 0, "R5", "patterns left", exp_q.size(), 0);
    for (int c = 0; c < 3; c++) @(negedge clk);
    check(all_done == 1'b1 && ld_cnt == n, "R7", "done held", all_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!load && !mem_rd && !busy && !all_done, "R1", "outputs in reset",
          {load, mem_rd, busy, all_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!load && !mem_rd && !busy && !all_done && poly_idx == '0, "R1",
          "idle after reset", {load, mem_rd, busy, all_done}, 0);
    for (int c = 0; c < 2; c++) begin
      lfsr_done = 1'b1;
      @(negedge clk);
      check(!busy && !load, "R6", "done while idle", busy, 0);
    end
    lfsr_done = 1'b0;

    run(1'b0, 2, 6, 1, 1, 1'b0, 1'b0);   // R3 period 2
    run(1'b0, 3, 7, 3, 2, 1'b0, 1'b1);   // R3 R7 stop mid period, R9 stray start
    run(1'b1, 0, 10, 2, 3, 1'b1, 1'b0);  // R4 next-bit, R6 early done
    run(1'b0, 4, 9, 2, 4, 1'b0, 1'b0);   // R3 full q-bit wrap, R10 restart

    // R8 zero-length run
    rd_cnt = 0;
    ld_cnt = 0;
    count = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(all_done == 1'b1, "R8", "zero count done", all_done, 1);
    check(busy == 1'b0, "R8", "zero count busy", busy, 0);
    for (int c = 0; c < 3; c++) @(negedge clk);
    check(rd_cnt == 0 && ld_cnt == 0, "R8", "activity on zero count", rd_cnt + ld_cnt, 0);

    run(1'b1, 0, 12, 1, 5, 1'b0, 1'b0);  // R4 with wrap of the index
    run(1'b0, 1, 3, 1, 6, 1'b0, 1'b0);   // R3 single polynomial

    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end
endmodule